// File: doc/BRIEF.md
# Ternary Symbol-Pair Transceiver

This block carries 3-bit data groups over a line whose symbols take three levels: -1, 0 and +1. The transmit half takes one group per valid/ready handshake and sends it as two consecutive ternary symbols. That gives 1.5 bits per symbol time. Eight of the nine possible level pairs carry data. The pair (0,0) is reserved and never sent.

The receive half collects symbols into groups and rebuilds the 3-bit value. It raises an error flag for the reserved pair and for any illegal symbol code. It also marks the first symbol of each group, so the framing can be watched from outside.

A mode input selects a lower-power binary mode instead. In binary mode each symbol time carries a single bit at level -1 or +1, so a group takes three symbols. The mode is sampled once per group, at the group's first symbol, on each side separately. Analog levels, equalization, clock recovery and error correction belong to other blocks.

Top module: `tern_pair_link`

## Requirements
- R1: Symbol codes on all symbol ports are 2'b10 for -1, 2'b00 for 0 and 2'b01 for +1. In ternary mode (`modeBin`=0), an accepted group is sent on `txSym` in the two cycles after the accepting edge, with `txSymValid` high in both.
- R2: The ternary map is 000→(-1,-1), 001→(-1,0), 010→(-1,+1), 011→(0,-1), 100→(0,+1), 101→(+1,-1), 110→(+1,0) and 111→(+1,+1), with the first symbol of each pair listed first. The pair (0,0) is never transmitted.
- R3: `txReady` is high whenever no symbol is pending after the one now on `txSym`. A group offered in the cycle that shows the last symbol follows on the very next cycle, with no idle gap. When nothing follows, `txSymValid` drops to 0 and `txSym` goes to 2'b00.
- R4: In binary mode (`modeBin`=1), an accepted group is sent as three symbols, most significant bit first, with bit 0 sent as 2'b10 and bit 1 sent as 2'b01.
- R5: The transmit mode is taken from `modeBin` at the accepting edge. Changes to `modeBin` while a group is being sent have no effect on that group's symbols.
- R6: In ternary mode, one cycle after the edge that captures the second symbol of a group, `rxValid` pulses for one cycle. At the same time `rxData` carries the decoded group per the R2 map, and `rxErr` is 0.
- R7: A received pair (0,0) gives the `rxValid` pulse with `rxErr`=1 and `rxData`=000.
- R8: A received symbol code 2'b11 in any slot gives the `rxValid` pulse with `rxErr`=1 and `rxData`=000. In binary mode, a level of 0 in any slot has the same result.
- R9: In binary mode the receiver rebuilds the group from three symbols, most significant bit first (2'b10 is 0 and 2'b01 is 1). The `rxValid` pulse comes one cycle after the third symbol.
- R10: `rxFrameStart` is high exactly in the cycles where `rxSymValid` presents the first symbol of a group. The receive mode is taken from `modeBin` in that cycle and held for the rest of the group.
- R11: Cycles with `rxSymValid` low neither advance the group nor produce `rxValid` or `rxFrameStart`.
- R12: During reset, `txReady`=1, `txSymValid`=0, `txSym`=2'b00, `rxValid`=0 and `rxErr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeBin | input | 1 | 1 selects binary mode, 0 selects ternary mode |
| txValid | input | 1 | Transmit group offered |
| txData | input | 3 | Transmit group |
| txReady | output | 1 | Transmit side can accept a group |
| txSym | output | 2 | Transmit symbol code |
| txSymValid | output | 1 | Transmit symbol present |
| rxSymValid | input | 1 | Receive symbol present |
| rxSym | input | 2 | Receive symbol code |
| rxFrameStart | output | 1 | Current receive symbol starts a group |
| rxValid | output | 1 | Decoded group available (one-cycle pulse) |
| rxData | output | 3 | Decoded group |
| rxErr | output | 1 | Decoded pair or symbol was illegal |

## Verification
The transmit half can accept a new group in the same cycle that the receive half completes one. In loopback runs the bench feeds `txSym` straight back into the receiver while it keeps the transmit handshake saturated, so acceptances and decode pulses overlap on most cycles. Every decoded group is compared, in order, against the queue of groups the bench offered. The same runs check that acceptance never disturbs the receive frame counter, and that a decode never holds off `txReady`.

// File: rtl/tern_pkg.sv
package tern_pkg;

  typedef logic [1:0] sym_t;

  localparam sym_t SYM_NEG  = 2'b10;
  localparam sym_t SYM_ZERO = 2'b00;
  localparam sym_t SYM_POS  = 2'b01;

  localparam int GRP_W    = 3;
  localparam int SYM_W    = 2;
  localparam int TERN_LEN = 2;
  localparam int NRZ_LEN  = 3;
  localparam int MAX_LEN  = (NRZ_LEN > TERN_LEN) ? NRZ_LEN : TERN_LEN;
  localparam int CNT_W    = $clog2(MAX_LEN);
  localparam int SHR_W    = SYM_W * MAX_LEN;
  localparam int HOLD_N   = MAX_LEN - 1;

  typedef struct packed {
    logic load;
    logic shift;
    logic binMode;
  } tx_strb_t;

  typedef struct packed {
    logic             capture;
    logic             finish;
    logic [CNT_W-1:0] slot;
    logic             binMode;
  } rx_strb_t;

  // trit 0,1,2 -> level -1,0,+1
  function automatic sym_t tritSym(input logic [1:0] t);
    case (t)
      2'd0:    return SYM_NEG;
      2'd1:    return SYM_ZERO;
      default: return SYM_POS;
    endcase
  endfunction

  // level code -> trit, 3 marks an illegal code
  function automatic logic [1:0] symTrit(input sym_t s);
    case (s)
      SYM_NEG:  return 2'd0;
      SYM_ZERO: return 2'd1;
      SYM_POS:  return 2'd2;
      default:  return 2'd3;
    endcase
  endfunction

  // Build the symbol sequence for one group, first symbol in the top slot.
  function automatic logic [SHR_W-1:0] encodeGroup(input logic bin,
                                                   input logic [GRP_W-1:0] d);
    logic [SHR_W-1:0] res;
    logic [3:0] idx, q, r;
    res = '0;
    if (bin) begin
      for (int i = 0; i < NRZ_LEN; i++)
        res[SYM_W*(MAX_LEN-1-i) +: SYM_W] = d[GRP_W-1-i] ? SYM_POS : SYM_NEG;
    end else begin
      // skip base-3 index 4, the reserved middle pair
      idx = (d < 3'd4) ? {1'b0, d} : ({1'b0, d} + 4'd1);
      q   = idx / 4'd3;
      r   = idx % 4'd3;
      res[SYM_W*(MAX_LEN-1) +: SYM_W] = tritSym(q[1:0]);
      res[SYM_W*(MAX_LEN-2) +: SYM_W] = tritSym(r[1:0]);
    end
    return res;
  endfunction

  // Returns {err, data}
  function automatic logic [GRP_W:0] decodeTern(input sym_t a, input sym_t b);
    logic [1:0] ta, tb;
    logic [3:0] idx;
    ta  = symTrit(a);
    tb  = symTrit(b);
    idx = ({2'b00, ta} * 4'd3) + {2'b00, tb};
    if (ta == 2'd3 || tb == 2'd3 || idx == 4'd4)
      return '0 | (1 << GRP_W);
    else if (idx < 4'd4)
      return {1'b0, idx[GRP_W-1:0]};
    else
      return {1'b0, 3'(idx - 4'd1)};
  endfunction

  function automatic logic [GRP_W:0] decodeNrz(input logic [SYM_W*NRZ_LEN-1:0] s);
    logic [GRP_W-1:0] d;
    logic bad;
    d   = '0;
    bad = 1'b0;
    for (int i = 0; i < NRZ_LEN; i++) begin
      case (s[SYM_W*(NRZ_LEN-1-i) +: SYM_W])
        SYM_NEG: d[GRP_W-1-i] = 1'b0;
        SYM_POS: d[GRP_W-1-i] = 1'b1;
        default: bad = 1'b1;
      endcase
    end
    return bad ? ('0 | (1 << GRP_W)) : {1'b0, d};
  endfunction

endpackage

// File: rtl/tern_ctrl.sv
module tern_ctrl
  import tern_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     modeBin,
  input  logic     txValid,
  input  logic     rxSymValid,
  output logic     txReady,
  output logic     txSymValid,
  output logic     rxFrameStart,
  output tx_strb_t txStrb,
  output rx_strb_t rxStrb
);

  localparam logic [CNT_W-1:0] TERN_LAST = CNT_W'(TERN_LEN - 1);
  localparam logic [CNT_W-1:0] NRZ_LAST  = CNT_W'(NRZ_LEN - 1);

  // transmit sequencing
  logic [CNT_W-1:0] txRem;
  logic             txOn;
  logic             accept;

  assign txReady    = (txRem == '0);
  assign accept     = txValid && txReady;
  assign txSymValid = txOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txRem <= '0;
      txOn  <= 1'b0;
    end else if (accept) begin
      txRem <= modeBin ? NRZ_LAST : TERN_LAST;
      txOn  <= 1'b1;
    end else if (txRem != '0) begin
      txRem <= txRem - 1'b1;
    end else begin
      txOn  <= 1'b0;
    end
  end

  always_comb begin
    txStrb.load    = accept;
    txStrb.shift   = !accept && (txRem != '0);
    txStrb.binMode = modeBin;
  end

  // receive framing
  logic [CNT_W-1:0] rxCnt;
  logic             rxModeLat;
  logic             atFirst;
  logic             effMode;
  logic [CNT_W-1:0] lastSlot;
  logic             isLast;

  assign atFirst      = (rxCnt == '0);
  assign effMode      = atFirst ? modeBin : rxModeLat;
  assign lastSlot     = effMode ? NRZ_LAST : TERN_LAST;
  assign isLast       = rxSymValid && (rxCnt == lastSlot);
  assign rxFrameStart = rxSymValid && atFirst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCnt     <= '0;
      rxModeLat <= 1'b0;
    end else if (rxSymValid) begin
      if (atFirst) rxModeLat <= modeBin;
      rxCnt <= isLast ? '0 : (rxCnt + 1'b1);
    end
  end

  always_comb begin
    rxStrb.capture = rxSymValid && !isLast;
    rxStrb.finish  = isLast;
    rxStrb.slot    = rxCnt;
    rxStrb.binMode = effMode;
  end

endmodule

// File: rtl/tern_dpath.sv
module tern_dpath
  import tern_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [GRP_W-1:0] txData,
  input  tx_strb_t         txStrb,
  output logic [SYM_W-1:0] txSym,
  input  logic [SYM_W-1:0] rxSym,
  input  rx_strb_t         rxStrb,
  output logic             rxValid,
  output logic [GRP_W-1:0] rxData,
  output logic             rxErr
);

  // transmit shift register, first symbol in the top slot
  logic [SHR_W-1:0] txShr;

  always_ff @(posedge clk) begin
    if (!rstN)             txShr <= '0;
    else if (txStrb.load)  txShr <= encodeGroup(txStrb.binMode, txData);
    else if (txStrb.shift) txShr <= {txShr[SHR_W-SYM_W-1:0], {SYM_W{1'b0}}};
    else                   txShr <= '0;
  end

  assign txSym = txShr[SHR_W-1 -: SYM_W];

  // receive holding slots, one per non-final symbol
  sym_t hold [HOLD_N];

  for (genvar g = 0; g < HOLD_N; g++) begin : gHold
    always_ff @(posedge clk) begin
      if (!rstN)
        hold[g] <= SYM_ZERO;
      else if (rxStrb.capture && rxStrb.slot == CNT_W'(g))
        hold[g] <= rxSym;
    end
  end

  logic [GRP_W:0] ternRes, nrzRes, pick;

  always_comb begin
    ternRes = decodeTern(hold[0], rxSym);
    nrzRes  = decodeNrz({hold[0], hold[1], rxSym});
    pick    = rxStrb.binMode ? nrzRes : ternRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxData  <= '0;
      rxErr   <= 1'b0;
    end else begin
      rxValid <= rxStrb.finish;
      if (rxStrb.finish) begin
        rxData <= pick[GRP_W-1:0];
        rxErr  <= pick[GRP_W];
      end
    end
  end

endmodule

// File: rtl/tern_pair_link.sv
module tern_pair_link
  import tern_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeBin,
  input  logic       txValid,
  input  logic [2:0] txData,
  output logic       txReady,
  output logic [1:0] txSym,
  output logic       txSymValid,
  input  logic       rxSymValid,
  input  logic [1:0] rxSym,
  output logic       rxFrameStart,
  output logic       rxValid,
  output logic [2:0] rxData,
  output logic       rxErr
);

  tx_strb_t txStrb;
  rx_strb_t rxStrb;

  tern_ctrl ctrlI (
    .clk          (clk),
    .rstN         (rstN),
    .modeBin      (modeBin),
    .txValid      (txValid),
    .rxSymValid   (rxSymValid),
    .txReady      (txReady),
    .txSymValid   (txSymValid),
    .rxFrameStart (rxFrameStart),
    .txStrb       (txStrb),
    .rxStrb       (rxStrb)
  );

  tern_dpath dpathI (
    .clk     (clk),
    .rstN    (rstN),
    .txData  (txData),
    .txStrb  (txStrb),
    .txSym   (txSym),
    .rxSym   (rxSym),
    .rxStrb  (rxStrb),
    .rxValid (rxValid),
    .rxData  (rxData),
    .rxErr   (rxErr)
  );

endmodule

// File: rtl/tern_pair_chk.sv
module tern_pair_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txReady,
  input logic [1:0] txSym,
  input logic       txSymValid,
  input logic       rxSymValid,
  input logic       rxFrameStart,
  input logic       rxValid,
  input logic [2:0] rxData,
  input logic       rxErr
);

  // R1
  no_bad_tx_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    txSymValid |-> txSym != 2'b11);

  // R3
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txSymValid |-> txReady);

  // R3
  no_mid_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txSymValid && !txReady) |=> txSymValid);

  // R3
  idle_sym_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txSymValid |-> txSym == 2'b00);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R7
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxErr) |-> rxData == 3'b000);

  // R10
  frame_needs_sym_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxFrameStart |-> rxSymValid);

endmodule

bind tern_pair_link tern_pair_chk chkI (
  .clk          (clk),
  .rstN         (rstN),
  .txReady      (txReady),
  .txSym        (txSym),
  .txSymValid   (txSymValid),
  .rxSymValid   (rxSymValid),
  .rxFrameStart (rxFrameStart),
  .rxValid      (rxValid),
  .rxData       (rxData),
  .rxErr        (rxErr)
);

// File: tb/tb_tern_pair_link.sv
module tb_tern_pair_link;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeBin = 1'b0;
  logic       txValid = 1'b0;
  logic [2:0] txData = 3'b000;
  logic       txReady, txSymValid, rxFrameStart, rxValid, rxErr;
  logic [1:0] txSym;
  logic [2:0] rxData;
  logic       drvSymValid = 1'b0;
  logic [1:0] drvSym = 2'b00;
  logic       loopEn = 1'b0;
  logic       rxSymValidIn;
  logic [1:0] rxSymIn;

  int nChk = 0;
  int nFail = 0;
  logic [2:0] sentQ [$];

  always #2 clk = ~clk;

  assign rxSymValidIn = loopEn ? txSymValid : drvSymValid;
  assign rxSymIn      = loopEn ? txSym : drvSym;

  tern_pair_link dut (
    .clk(clk), .rstN(rstN), .modeBin(modeBin),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .txSym(txSym), .txSymValid(txSymValid),
    .rxSymValid(rxSymValidIn), .rxSym(rxSymIn),
    .rxFrameStart(rxFrameStart), .rxValid(rxValid),
    .rxData(rxData), .rxErr(rxErr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected symbol sequence, first symbol in bits [5:4]
  function automatic logic [5:0] expSyms(input bit bin, input logic [2:0] d);
    logic [5:0] r;
    if (bin) begin
      for (int i = 0; i < 3; i++) r[4-2*i +: 2] = d[2-i] ? 2'b01 : 2'b10;
    end else begin
      case (d)
        3'd0: r = {2'b10, 2'b10, 2'b00};
        3'd1: r = {2'b10, 2'b00, 2'b00};
        3'd2: r = {2'b10, 2'b01, 2'b00};
        3'd3: r = {2'b00, 2'b10, 2'b00};
        3'd4: r = {2'b00, 2'b01, 2'b00};
        3'd5: r = {2'b01, 2'b10, 2'b00};
        3'd6: r = {2'b01, 2'b00, 2'b00};
        default: r = {2'b01, 2'b01, 2'b00};
      endcase
    end
    return r;
  endfunction

  // expected {err, data} for a received group
  function automatic logic [3:0] expDec(input bit bin, input logic [5:0] s);
    logic [2:0] d;
    if (bin) begin
      for (int i = 0; i < 3; i++) begin
        if (s[4-2*i +: 2] == 2'b01) d[2-i] = 1'b1;
        else if (s[4-2*i +: 2] == 2'b10) d[2-i] = 1'b0;
        else return 4'b1000;
      end
      return {1'b0, d};
    end
    for (int v = 0; v < 8; v++) begin
      logic [5:0] e;
      e = expSyms(1'b0, 3'(v));
      if (e[5:2] == s[5:2]) return {1'b0, 3'(v)};
    end
    return 4'b1000;
  endfunction

  function automatic logic [1:0] randSym(input bit allowBad);
    int k;
    k = allowBad ? $urandom_range(0, 9) : $urandom_range(0, 8);
    if (k == 9) return 2'b11;
    return (k % 3 == 0) ? 2'b10 : (k % 3 == 1) ? 2'b00 : 2'b01;
  endfunction

  // Send groups on the transmit side and check every symbol (R1..R5).
  task automatic txBurst(input int count, input bit b2b, input int modeSel,
                         input bit midFlip, input bit fixedVals);
    @(negedge clk);
    for (int k = 0; k < count; k++) begin
      bit m;
      logic [2:0] d;
      logic [5:0] e;
      int n;
      m = (modeSel == 2) ? bit'($urandom_range(0, 1)) : bit'(modeSel);
      d = fixedVals ? 3'(k) : 3'($urandom_range(0, 7));
      e = expSyms(m, d);
      n = m ? 3 : 2;
      chk(txReady == 1'b1, "R3", "ready when offered", txReady, 1);
      txValid = 1'b1; txData = d; modeBin = m;
      if (loopEn) sentQ.push_back(d);
      @(negedge clk);
      txValid = 1'b0; txData = 3'($urandom_range(0, 7));
      if (midFlip) modeBin = ~m;
      for (int i = 0; i < n; i++) begin
        if (i > 0) @(negedge clk);
        chk(txSymValid == 1'b1, m ? "R4" : "R1", "symbol valid", txSymValid, 1);
        chk(txSym == e[4-2*i +: 2], m ? (midFlip ? "R5" : "R4") : "R2",
            "symbol code", txSym, e[4-2*i +: 2]);
        chk(txReady == (i == n - 1), "R3", "ready timing", txReady, i == n - 1);
      end
      if (!b2b) begin
        @(negedge clk);
        chk(txSymValid == 1'b0 && txSym == 2'b00, "R3", "idle after group",
            {txSymValid, txSym}, 0);
      end
    end
  endtask

  // Drive one receive group and check framing and decode (R6..R11).
  task automatic rxGroup(input bit m, input logic [5:0] s, input bit gaps);
    int n;
    logic [3:0] x;
    n = m ? 3 : 2;
    x = expDec(m, s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gaps && $urandom_range(0, 2) == 0) begin
        drvSymValid = 1'b0; drvSym = randSym(1'b1);
        modeBin = ~modeBin;
        #1;
        chk(rxFrameStart == 1'b0, "R11", "no frame strobe in gap", rxFrameStart, 0);
        chk(rxValid == 1'b0, "R11", "no pulse in gap", rxValid, 0);
        @(negedge clk);
      end
      drvSymValid = 1'b1; drvSym = s[4-2*i +: 2];
      modeBin = (i == 0) ? m : ~m;
      #1;
      chk(rxFrameStart == (i == 0), "R10", "frame strobe", rxFrameStart, i == 0);
      if (i > 0) chk(rxValid == 1'b0, "R6", "no early pulse", rxValid, 0);
    end
    @(negedge clk);
    drvSymValid = 1'b0; drvSym = 2'b00;
    chk(rxValid == 1'b1, m ? "R9" : "R6", "decode pulse", rxValid, 1);
    chk({rxErr, rxData} == x, x[3] ? (s[5:4] == 2'b11 || s[3:2] == 2'b11 || m ? "R8" : "R7")
                                   : (m ? "R9" : "R6"),
        "decode value", {rxErr, rxData}, x);
  endtask

  // loopback comparison
  always @(negedge clk) begin
    if (loopEn && rxValid) begin
      if (sentQ.size() == 0) chk(1'b0, "R6", "unexpected loopback decode", rxData, 0);
      else begin
        logic [2:0] want;
        want = sentQ.pop_front();
        chk(rxData == want && !rxErr, modeBin ? "R9" : "R6", "loopback group",
            {rxErr, rxData}, want);
      end
    end
  end

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R12
    chk(txReady == 1'b1 && txSymValid == 1'b0 && txSym == 2'b00, "R12",
        "tx reset state", {txReady, txSymValid, txSym}, 4'b1000);
    chk(rxValid == 1'b0 && rxErr == 1'b0, "R12", "rx reset state",
        {rxValid, rxErr}, 0);
    rstN = 1'b1;

    // directed: every ternary and binary value, spaced and back-to-back
    txBurst(8, 1'b0, 0, 1'b0, 1'b1);
    txBurst(8, 1'b1, 0, 1'b0, 1'b1);
    txBurst(8, 1'b0, 1, 1'b0, 1'b1);
    txBurst(8, 1'b1, 1, 1'b0, 1'b1);
    // R5: mode flips mid-group
    txBurst(40, 1'b1, 2, 1'b1, 1'b0);
    txBurst(40, 1'b0, 2, 1'b1, 1'b0);

    // directed receive: all nine ternary pairs, illegal codes, binary zero level
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++) begin
        logic [1:0] sa, sb;
        sa = (a == 0) ? 2'b10 : (a == 1) ? 2'b00 : 2'b01;
        sb = (b == 0) ? 2'b10 : (b == 1) ? 2'b00 : 2'b01;
        rxGroup(1'b0, {sa, sb, 2'b00}, 1'b0);
      end
    rxGroup(1'b0, {2'b11, 2'b01, 2'b00}, 1'b0);
    rxGroup(1'b0, {2'b10, 2'b11, 2'b00}, 1'b0);
    rxGroup(1'b1, {2'b01, 2'b10, 2'b01}, 1'b0);
    rxGroup(1'b1, {2'b01, 2'b00, 2'b01}, 1'b0);
    rxGroup(1'b1, {2'b10, 2'b10, 2'b11}, 1'b0);

    // random receive with gaps and mixed modes
    for (int k = 0; k < 300; k++)
      rxGroup(bit'($urandom_range(0, 1)),
              {randSym(1'b1), randSym(1'b1), randSym(1'b1)}, 1'b1);

    // loopback: transmit acceptance overlapping receive decode
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      loopEn = 1'b1;
      txBurst(200, 1'b1, m, 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      chk(sentQ.size() == 0, "R6", "loopback queue drained", sentQ.size(), 0);
      loopEn = 1'b0;
      sentQ.delete();
    end

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule